// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block is a pulse-width modulation timer with eight output channels that all share one up-counter and therefore one period. The counter advances on a tick chosen from three sources (every system clock, or one of two qualified count-enable inputs), thinned out by a power-of-two prescaler. It counts from a programmable start value up to a programmable limit and then restarts, so the period is the limit minus the start value plus one counts.

Each channel compares the live count against its own width value. In edge-aligned mode a channel is active from the restart of the count until the count reaches its value. A per-channel inversion bit and a per-channel mask shape the final pin level. The limit and the width values are double-buffered: software writes a shadow copy that the counter adopts only when it restarts, so a running period is never cut short. A plain 32-bit register bus with a combinational read path gives software access.

Top module: `pwmTimer`

## Requirements
- R1: After reset every output is low, the mask register reads 0xFF, the counter reads 0 and the status/control register reads 0.
- R2: Registers are decoded by byte address: status/control 0x00, counter 0x04, limit 0x08, channel n mode 0x0C+8n (8 bits), channel n width 0x10+8n, start value 0x4C, idle level 0x5C, mask 0x60, inversion 0x70. A written register reads back its written value.
- R3: Status/control bits [4:3] pick the tick: 0 stops the counter, 1 ticks on every system clock, 2 on each cycle with `fixTick` high, 3 on each cycle with `extTick` high.
- R4: Status/control bits [2:0] hold an exponent ps; the counter advances once per 2^ps selected ticks.
- R5: The counter steps from the start value up to the active limit and then reloads the start value, giving a period of limit-start+1 counts.
- R6: Reading 0x04 returns the live count; any write to 0x04 reloads the counter with the start value at once, clears the prescaler, and adopts the shadow limit and widths.
- R7: A written limit or channel width takes effect only at the next reload; the period in progress finishes with the old values.
- R8: A channel whose mode register has bits 5 and 3 both set is edge-aligned: its raw output is active while the count is below its active width, so width 0 is never active and a width above the limit is always active.
- R9: Inversion bit n flips output n.
- R10: Mask bit n forces output n to its inactive level, which is inversion bit n.
- R11: An unmasked channel not in edge-aligned mode drives idle-level bit n, flipped by inversion bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr (combinational) |
| fixTick | input | 1 | Count enable for the fixed-rate source |
| extTick | input | 1 | Count enable for the external source |
| pwmOut | output | 8 | Channel outputs |

## Verification
Register writes land on the clock edge that samples `busWe`, and a counter write reloads the count on that same edge, so the count read at the following falling edge already shows the start value. Outputs are registered-state functions with no bus path, so they change only on rising edges and the bench samples them on falling edges; widths are checked by counting active samples over a whole number of periods, which makes the result independent of phase. Shadow behaviour is checked by writing at a known count (well away from the limit) and observing the maximum count before the next two restarts.

// File: rtl/pwmTimerPkg.sv
package pwmTimerPkg;
  localparam logic [7:0] ADDR_SC    = 8'h00;
  localparam logic [7:0] ADDR_CNT   = 8'h04;
  localparam logic [7:0] ADDR_LIM   = 8'h08;
  localparam logic [7:0] ADDR_START = 8'h4C;
  localparam logic [7:0] ADDR_IDLE  = 8'h5C;
  localparam logic [7:0] ADDR_MASK  = 8'h60;
  localparam logic [7:0] ADDR_INV   = 8'h70;
  localparam int CH_MODE_BASE = 12;
  localparam int CH_WIDTH_BASE = 16;
  localparam int CH_STRIDE = 8;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } tickSrcT;

  typedef struct packed {
    logic    cntWr;
    tickSrcT src;
    logic [2:0] psExp;
  } dpCtlT;

  function automatic logic [7:0] chModeAddr(input int n);
    return 8'(CH_MODE_BASE + CH_STRIDE * n);
  endfunction

  function automatic logic [7:0] chWidthAddr(input int n);
    return 8'(CH_WIDTH_BASE + CH_STRIDE * n);
  endfunction
endpackage

// File: rtl/pwmRegs.sv
module pwmRegs
  import pwmTimerPkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWe,
  input  logic [7:0]               busAddr,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  logic [CW-1:0]            cntLive,
  output dpCtlT                    dpCtl,
  output logic [CW-1:0]            limShadow,
  output logic [CW-1:0]            startVal,
  output logic [NCH-1:0][CW-1:0]   widthShadow,
  output logic [NCH-1:0]           chEdge,
  output logic [NCH-1:0]           maskQ,
  output logic [NCH-1:0]           invQ,
  output logic [NCH-1:0]           idleQ
);
  logic [4:0] scReg;
  logic [NCH-1:0][7:0] modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scReg       <= '0;
      limShadow   <= '0;
      startVal    <= '0;
      maskQ       <= '1;
      invQ        <= '0;
      idleQ       <= '0;
      modeReg     <= '0;
      widthShadow <= '0;
    end else if (busWe) begin
      if (busAddr == ADDR_SC)    scReg     <= busWdata[4:0];
      if (busAddr == ADDR_LIM)   limShadow <= busWdata[CW-1:0];
      if (busAddr == ADDR_START) startVal  <= busWdata[CW-1:0];
      if (busAddr == ADDR_MASK)  maskQ     <= busWdata[NCH-1:0];
      if (busAddr == ADDR_INV)   invQ      <= busWdata[NCH-1:0];
      if (busAddr == ADDR_IDLE)  idleQ     <= busWdata[NCH-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (busAddr == chModeAddr(n))  modeReg[n]     <= busWdata[7:0];
        if (busAddr == chWidthAddr(n)) widthShadow[n] <= busWdata[CW-1:0];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_SC:    busRdata[4:0]     = scReg;
      ADDR_CNT:   busRdata[CW-1:0]  = cntLive;
      ADDR_LIM:   busRdata[CW-1:0]  = limShadow;
      ADDR_START: busRdata[CW-1:0]  = startVal;
      ADDR_MASK:  busRdata[NCH-1:0] = maskQ;
      ADDR_INV:   busRdata[NCH-1:0] = invQ;
      ADDR_IDLE:  busRdata[NCH-1:0] = idleQ;
      default:    busRdata          = '0;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (busAddr == chModeAddr(n))  busRdata[7:0]    = modeReg[n];
      if (busAddr == chWidthAddr(n)) busRdata[CW-1:0] = widthShadow[n];
    end
  end

  assign dpCtl.cntWr = busWe && (busAddr == ADDR_CNT);
  assign dpCtl.src   = tickSrcT'(scReg[4:3]);
  assign dpCtl.psExp = scReg[2:0];

  for (genvar g = 0; g < NCH; g++) begin : gMode
    assign chEdge[g] = modeReg[g][5] & modeReg[g][3];
  end

  // R10 / R2: mask register captures the bus data on a write
  a_r10_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_MASK) |=> (maskQ == $past(busWdata[NCH-1:0])));

  // R2: limit shadow holds unless written
  a_r2_lim_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == ADDR_LIM) |=> $stable(limShadow));
endmodule

// File: rtl/pwmCore.sv
module pwmCore
  import pwmTimerPkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PSW = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtlT                  dpCtl,
  input  logic                   fixTick,
  input  logic                   extTick,
  input  logic [CW-1:0]          limShadow,
  input  logic [CW-1:0]          startVal,
  input  logic [NCH-1:0][CW-1:0] widthShadow,
  input  logic [NCH-1:0]         chEdge,
  input  logic [NCH-1:0]         maskQ,
  input  logic [NCH-1:0]         invQ,
  input  logic [NCH-1:0]         idleQ,
  output logic [CW-1:0]          cntQ,
  output logic [NCH-1:0]         pwmOut
);
  logic [PSW-1:0] psCnt;
  logic [PSW-1:0] psMask;
  logic srcTick, step, wrap, reloadEv;
  logic [CW-1:0] limAct;
  logic [NCH-1:0][CW-1:0] widthAct;

  always_comb begin
    case (dpCtl.src)
      SRC_SYS: srcTick = 1'b1;
      SRC_FIX: srcTick = fixTick;
      SRC_EXT: srcTick = extTick;
      default: srcTick = 1'b0;
    endcase
  end

  assign psMask   = PSW'((PSW+1)'(1) << dpCtl.psExp) - PSW'(1);
  assign step     = srcTick && ((psCnt & psMask) == psMask);
  assign wrap     = step && (cntQ >= limAct);
  assign reloadEv = wrap || dpCtl.cntWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt    <= '0;
      cntQ     <= '0;
      limAct   <= '0;
      widthAct <= '0;
    end else begin
      if (dpCtl.cntWr) begin
        psCnt <= '0;
        cntQ  <= startVal;
      end else if (srcTick) begin
        psCnt <= psCnt + PSW'(1);
        if (step) cntQ <= wrap ? startVal : cntQ + CW'(1);
      end
      if (reloadEv) begin
        limAct   <= limShadow;
        widthAct <= widthShadow;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gCh
    logic rawAct, drive;
    assign rawAct    = cntQ < widthAct[g];
    assign drive     = chEdge[g] ? rawAct : idleQ[g];
    assign pwmOut[g] = (drive & ~maskQ[g]) ^ invQ[g];

    // R10: a masked channel sits at its inactive level
    a_r10_masked_level: assert property (@(posedge clk) disable iff (!rstN)
      maskQ[g] |-> (pwmOut[g] == invQ[g]));
  end

  // R3: a stopped source freezes the count
  a_r3_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.src == SRC_OFF && !dpCtl.cntWr) |=> $stable(cntQ));

  // R5: a wrap restarts from the start value
  a_r5_wrap_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && !dpCtl.cntWr) |=> (cntQ == $past(startVal)));

  // R6: a counter write reloads the start value
  a_r6_cnt_write: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.cntWr |=> (cntQ == $past(startVal)));

  // R7: active limit changes only at a reload
  a_r7_lim_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reloadEv |=> $stable(limAct));
endmodule

// File: rtl/pwmTimer.sv
module pwmTimer
  import pwmTimerPkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWe,
  input  logic [7:0]     busAddr,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  input  logic           fixTick,
  input  logic           extTick,
  output logic [NCH-1:0] pwmOut
);
  dpCtlT                  dpCtl;
  logic [CW-1:0]          cntLive, limShadow, startVal;
  logic [NCH-1:0][CW-1:0] widthShadow;
  logic [NCH-1:0]         chEdge, maskQ, invQ, idleQ;

  pwmRegs #(.NCH(NCH), .CW(CW)) uRegs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntLive(cntLive),
    .dpCtl(dpCtl), .limShadow(limShadow), .startVal(startVal),
    .widthShadow(widthShadow), .chEdge(chEdge), .maskQ(maskQ),
    .invQ(invQ), .idleQ(idleQ)
  );

  pwmCore #(.NCH(NCH), .CW(CW)) uCore (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .fixTick(fixTick),
    .extTick(extTick), .limShadow(limShadow), .startVal(startVal),
    .widthShadow(widthShadow), .chEdge(chEdge), .maskQ(maskQ),
    .invQ(invQ), .idleQ(idleQ), .cntQ(cntLive), .pwmOut(pwmOut)
  );
endmodule

// File: tb/sim_pwmTimer.sv
module sim_pwmTimer;
  logic clk = 0, rstN = 0, busWe = 0, fixTick = 0, extTick = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [7:0] pwmOut;
  int nRun = 0, nFail = 0, tickDiv = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwmTimer u0 (.clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .fixTick(fixTick),
    .extTick(extTick), .pwmOut(pwmOut));

  always @(negedge clk) begin
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    fixTick = (tickDiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); busAddr = a; #1; d = int'(busRdata);
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); #1; h += int'(pwmOut[ch]); end
  endtask

  task automatic waitCnt(input int v);
    int c;
    for (int i = 0; i < 400; i++) begin rd(8'h04, c); if (c == v) break; end
  endtask

  task automatic t_reset();
    int d;
    #1; chk(pwmOut == 8'h00, "R1 outputs", pwmOut, 0);
    rd(8'h60, d); chk(d == 8'hFF, "R1 mask", d, 255);
    rd(8'h04, d); chk(d == 0, "R1 count", d, 0);
    rd(8'h00, d); chk(d == 0, "R1 ctrl", d, 0);
  endtask

  task automatic t_basic();
    int d, h;
    wr(8'h4C, 0); wr(8'h08, 9); wr(8'h0C, 32'h28); wr(8'h10, 3);
    wr(8'h60, 32'hFE); wr(8'h04, 0); wr(8'h00, 32'h08);
    highs(0, 10, h); chk(h == 3, "R8 width 3 of 10", h, 3);
    rd(8'h0C, d); chk(d == 32'h28, "R2 mode readback", d, 40);
    rd(8'h10, d); chk(d == 3, "R2 width readback", d, 3);
    rd(8'h08, d); chk(d == 9, "R2 limit readback", d, 9);
  endtask

  task automatic t_range();
    int d, mx = 0, mn = 1000;
    for (int i = 0; i < 25; i++) begin
      rd(8'h04, d); if (d > mx) mx = d; if (d < mn) mn = d;
    end
    chk(mx == 9, "R5 max count", mx, 9);
    chk(mn == 0, "R5 min count", mn, 0);
  endtask

  task automatic lastBeforeWrap(output int last);
    int prev, cur;
    rd(8'h04, prev); last = -1;
    for (int i = 0; i < 200; i++) begin
      rd(8'h04, cur);
      if (cur < prev) begin last = prev; break; end
      prev = cur;
    end
  endtask

  task automatic t_shadow();
    int m;
    waitCnt(2); wr(8'h08, 19);
    lastBeforeWrap(m); chk(m == 9, "R7 old limit finishes", m, 9);
    lastBeforeWrap(m); chk(m == 19, "R7 new limit after reload", m, 19);
    wr(8'h08, 9); wr(8'h04, 0);
    waitCnt(2); wr(8'h10, 8);
    waitCnt(5); #1; chk(pwmOut[0] == 1'b0, "R7 old width kept", pwmOut[0], 0);
    waitCnt(0); waitCnt(5); #1;
    chk(pwmOut[0] == 1'b1, "R7 new width after reload", pwmOut[0], 1);
    wr(8'h10, 3); wr(8'h04, 0);
  endtask

  task automatic t_edges();
    int h;
    wr(8'h10, 0); wr(8'h04, 0);
    highs(0, 10, h); chk(h == 0, "R8 width zero", h, 0);
    wr(8'h10, 12); wr(8'h04, 0);
    highs(0, 10, h); chk(h == 10, "R8 width above limit", h, 10);
    wr(8'h10, 3); wr(8'h04, 0);
  endtask

  task automatic t_inv_mask();
    int h;
    wr(8'h70, 1); highs(0, 10, h); chk(h == 7, "R9 inverted width", h, 7);
    wr(8'h60, 32'hFF); highs(0, 10, h); chk(h == 10, "R10 masked inverted", h, 10);
    wr(8'h70, 0); highs(0, 10, h); chk(h == 0, "R10 masked plain", h, 0);
    wr(8'h60, 32'hFE);
  endtask

  task automatic t_prescale();
    int h;
    wr(8'h00, 32'h0A); highs(0, 40, h); chk(h == 12, "R4 ps=2", h, 12);
  endtask

  task automatic t_source();
    int a, b, h;
    wr(8'h00, 32'h00); rd(8'h04, a); repeat (6) @(negedge clk); rd(8'h04, b);
    chk(a == b, "R3 stopped", b, a);
    wr(8'h00, 32'h10); highs(0, 30, h); chk(h == 9, "R3 fixed tick", h, 9);
    wr(8'h00, 32'h18); rd(8'h04, a); repeat (6) @(negedge clk); rd(8'h04, b);
    chk(a == b, "R3 ext idle", b, a);
    @(negedge clk); extTick = 1;
    highs(0, 10, h); chk(h == 3, "R3 ext tick", h, 3);
    @(negedge clk); extTick = 0;
  endtask

  task automatic t_reload();
    int d, mx = 0, mn = 1000;
    wr(8'h00, 0); wr(8'h4C, 5); wr(8'h04, 32'h1234);
    rd(8'h04, d); chk(d == 5, "R6 write reloads start", d, 5);
    wr(8'h00, 32'h08);
    for (int i = 0; i < 20; i++) begin
      rd(8'h04, d); if (d > mx) mx = d; if (d < mn) mn = d;
    end
    chk(mn == 5, "R5 min with start 5", mn, 5);
    chk(mx == 9, "R5 max with start 5", mx, 9);
    wr(8'h4C, 0); wr(8'h04, 0);
  endtask

  task automatic t_idle();
    wr(8'h60, 32'hFC); wr(8'h5C, 32'h02); #2;
    chk(pwmOut[1] == 1'b1, "R11 idle level", pwmOut[1], 1);
    wr(8'h70, 32'h02); #2;
    chk(pwmOut[1] == 1'b0, "R11 idle inverted", pwmOut[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset(); t_basic(); t_range(); t_shadow(); t_edges();
    t_inv_mask(); t_prescale(); t_source(); t_reload(); t_idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule